// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside the microcoded sequencer of a small 8-bit processor and decides which external interrupt, if any, is taken between two instructions. Each request line is watched for a rising edge, which sets a bit in a request register. A fixed-priority resolver picks the lowest-numbered pending request. An in-service register records the interrupts whose handlers have started, and it masks requests of equal or lower priority. A higher-priority request can therefore nest inside a running handler.

The sequencer drives the block with one-cycle strobes at the end of every instruction. A poll strobe asks whether a qualifying request exists, and the answer appears on the pending flag. Two acknowledge strobes follow. The first takes the winner into service and remembers its number. The second hands that number to the processor's interrupt-address register through a one-cycle load pulse. At the end of a handler, a completion strobe retires the highest-priority interrupt that is still in service. A global enable input gates every report and every acknowledge. At most one strobe is expected per cycle; if several arrive together, the first acknowledge wins, then the second, then completion, then the poll.

Top module: `irqc_top`

## Requirements
- R1: While reset is asserted and after it is released with no strobe, irq_pending and vec_load are 0 and vec_num is 0; the request and in-service registers are empty.
- R2: A request bit is set by a 0-to-1 transition of its line between two consecutive clock edges; a line held high sets it only once, so after that request has been taken, a later poll does not report it again.
- R3: Among pending requests that qualify, the line with the lowest index has the highest priority and is the one taken.
- R4: The cycle after a poll strobe, irq_pending shows whether a qualifying request existed at the poll; the flag then holds until the next poll or first acknowledge.
- R5: With int_enable low, a poll yields irq_pending = 0 and a first acknowledge takes nothing.
- R6: A first acknowledge with a qualifying request clears that request bit, sets its in-service bit, records its index, and clears irq_pending the next cycle.
- R7: The cycle after a second acknowledge, vec_load is 1 for exactly one cycle and vec_num equals the index recorded by the most recent effective first acknowledge.
- R8: A pending request qualifies only if its index is lower than every index currently in service.
- R9: A completion strobe clears the lowest-index set in-service bit and no other.
- R10: A first acknowledge with no qualifying request leaves the request register, the in-service register and the recorded index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | LINES | External interrupt request lines |
| int_enable | input | 1 | Global interrupt enable |
| ask_stb | input | 1 | Poll strobe issued after each instruction |
| ack1_stb | input | 1 | First acknowledge: take the winner into service |
| ack2_stb | input | 1 | Second acknowledge: deliver the vector |
| eoi_stb | input | 1 | End of interrupt: retire the top in-service entry |
| irq_pending | output | 1 | Result of the last poll |
| vec_load | output | 1 | One-cycle load pulse for the interrupt-address register |
| vec_num | output | IDX_W | Interrupt number delivered by the second acknowledge |

## Verification
Every output is registered, so the result of a strobe or a line edge shows one rising edge after the cycle in which it is applied. A line edge affects a poll only when the poll comes in a later cycle. The bench applies inputs on the falling edge. It updates its reference state as if the next rising edge had occurred, then samples all three outputs one nanosecond after that edge. The effect of in-service masking, completion and ignored acknowledges is seen only through later polls and vectors. The bench therefore compares every cycle and does not rely on single snapshots.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int MAX_LINES = 32;
  localparam int NONE_IDX  = MAX_LINES;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_ASK,
    OP_ACK1,
    OP_ACK2,
    OP_EOI
  } irqc_op_e;

  // Index of the lowest set bit, or NONE_IDX when the vector is empty.
  function automatic logic [5:0] lowest_set(input logic [MAX_LINES-1:0] v);
    logic [5:0] r;
    r = 6'(NONE_IDX);
    for (int i = MAX_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = 6'(i);
    end
    return r;
  endfunction

  // Turn a strobe set into a single operation; first acknowledge dominates.
  function automatic irqc_op_e decode_op(input logic ask, input logic a1,
                                         input logic a2, input logic eoi);
    if (a1)       return OP_ACK1;
    else if (a2)  return OP_ACK2;
    else if (eoi) return OP_EOI;
    else if (ask) return OP_ASK;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic [LINES-1:0] clr_oh,
  output logic [LINES-1:0] req,
  output logic [LINES-1:0] edge_seen
);

  logic [LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_cell
    assign edge_seen[g] = lines[g] & ~prev_q[g];

    // A new edge has precedence over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            req[g] <= 1'b0;
      else if (edge_seen[g]) req[g] <= 1'b1;
      else if (clr_oh[g])    req[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
  import irqc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] isr,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_ok
);

  logic [5:0] req_low;
  logic [5:0] isr_low;

  always_comb begin
    req_low = lowest_set(MAX_LINES'(req));
    isr_low = lowest_set(MAX_LINES'(isr));
    win_idx = req_low[IDX_W-1:0];
    // Empty in-service register yields NONE_IDX, which no line reaches.
    win_ok  = (req_low != 6'(NONE_IDX)) && (req_low < isr_low);
  end

endmodule

// File: rtl/irqc_isr_bank.sv
module irqc_isr_bank #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_oh,
  input  logic             retire,
  output logic [LINES-1:0] isr,
  output logic [LINES-1:0] retire_oh
);

  function automatic logic [LINES-1:0] isolate_low(input logic [LINES-1:0] v);
    return v & (~v + LINES'(1));
  endfunction

  assign retire_oh = retire ? isolate_low(isr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~retire_oh) | set_oh;
  end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int LINES = 8,
  parameter int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_lines,
  input  logic             int_enable,
  input  logic             ask_stb,
  input  logic             ack1_stb,
  input  logic             ack2_stb,
  input  logic             eoi_stb,
  output logic             irq_pending,
  output logic             vec_load,
  output logic [IDX_W-1:0] vec_num
);

  irqc_op_e         op;
  logic [LINES-1:0] req_vec;
  logic [LINES-1:0] edge_seen;
  logic [LINES-1:0] isr_vec;
  logic [LINES-1:0] grant_oh;
  logic [LINES-1:0] eoi_clr_oh;
  logic [IDX_W-1:0] win_idx;
  logic             win_ok;
  logic             candidate;
  logic             grant;
  logic [IDX_W-1:0] num_q;

  assign op        = decode_op(ask_stb, ack1_stb, ack2_stb, eoi_stb);
  assign candidate = int_enable & win_ok;
  assign grant     = (op == OP_ACK1) & candidate;
  assign grant_oh  = grant ? (LINES'(1) << win_idx) : '0;

  irqc_req_latch #(.LINES(LINES)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines     (irq_lines),
    .clr_oh    (grant_oh),
    .req       (req_vec),
    .edge_seen (edge_seen)
  );

  irqc_resolver #(.LINES(LINES), .IDX_W(IDX_W)) u_res (
    .req     (req_vec),
    .isr     (isr_vec),
    .win_idx (win_idx),
    .win_ok  (win_ok)
  );

  irqc_isr_bank #(.LINES(LINES)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_oh    (grant_oh),
    .retire    (op == OP_EOI),
    .isr       (isr_vec),
    .retire_oh (eoi_clr_oh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pending <= 1'b0;
      num_q       <= '0;
      vec_num     <= '0;
      vec_load    <= 1'b0;
    end else begin
      vec_load <= (op == OP_ACK2);
      unique case (op)
        OP_ASK:  irq_pending <= candidate;
        OP_ACK1: begin
          irq_pending <= 1'b0;
          if (grant) num_q <= win_idx;
        end
        OP_ACK2: vec_num <= num_q;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int LINES = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_enable,
  input logic             ask_stb,
  input logic             ack1_stb,
  input logic             ack2_stb,
  input logic             eoi_stb,
  input logic             irq_pending,
  input logic             vec_load,
  input logic [IDX_W-1:0] vec_num,
  input logic [IDX_W-1:0] num_q,
  input logic [LINES-1:0] isr_vec,
  input logic [LINES-1:0] grant_oh,
  input logic [LINES-1:0] eoi_clr_oh
);

  // R5
  ie_low_no_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ask_stb && !ack1_stb && !ack2_stb && !eoi_stb && !int_enable) |=> !irq_pending);

  // R5
  ie_low_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_enable |-> (grant_oh == '0));

  // R6
  grant_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh != '0) |=> ((isr_vec & $past(grant_oh)) != '0) && !irq_pending);

  // R3
  grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh));

  // R8
  grant_above_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_oh != '0) |-> (((grant_oh | (grant_oh - LINES'(1))) & isr_vec) == '0));

  // R7
  vector_delivered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack2_stb && !ack1_stb) |=> vec_load && (vec_num == $past(num_q)));

  // R7
  load_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack2_stb |=> !vec_load);

  // R9
  eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb && !ack1_stb && !ack2_stb && isr_vec != '0)
      |=> $countones(isr_vec) == $countones($past(isr_vec)) - 1);

  // R9
  eoi_clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr_oh));

endmodule

bind irqc_top irqc_checker #(.LINES(LINES), .IDX_W(IDX_W)) chk (.*);

// File: tb/irqc_top_test.sv
module irqc_top_test;

  localparam int LINES = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] irq_lines = '0;
  logic             int_enable = 1'b0;
  logic             ask_stb = 1'b0, ack1_stb = 1'b0, ack2_stb = 1'b0, eoi_stb = 1'b0;
  logic             irq_pending, vec_load;
  logic [IDX_W-1:0] vec_num;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  logic [LINES-1:0] m_req = '0, m_isr = '0, m_prev = '0;
  int               m_num = 0, m_vec = 0;
  bit               m_pend = 0, m_load = 0;

  always #2.5 clk = ~clk;

  irqc_top #(.LINES(LINES)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .int_enable(int_enable),
    .ask_stb(ask_stb), .ack1_stb(ack1_stb), .ack2_stb(ack2_stb), .eoi_stb(eoi_stb),
    .irq_pending(irq_pending), .vec_load(vec_load), .vec_num(vec_num)
  );

  // Highest priority = smallest index; returns -1 when empty.
  function automatic int top_bit(input logic [LINES-1:0] v);
    for (int i = 0; i < LINES; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit qualifies(input logic [LINES-1:0] r, input logic [LINES-1:0] s,
                                   output int w);
    int t;
    w = top_bit(r);
    t = top_bit(s);
    if (w < 0) return 0;
    return (t < 0) || (w < t);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [LINES-1:0] lv, input bit ie,
                     input bit ask, input bit a1, input bit a2, input bit eoi);
    logic [LINES-1:0] setv, clr;
    int w, t;
    bit q;
    string tag;
    @(negedge clk);
    irq_lines = lv; int_enable = ie;
    ask_stb = ask; ack1_stb = a1; ack2_stb = a2; eoi_stb = eoi;
    setv = lv & ~m_prev;
    q = qualifies(m_req, m_isr, w) && ie;
    clr = '0;
    tag = "R2";
    m_load = 0;
    if (ask) begin
      m_pend = q;
      tag = ie ? (m_isr != 0 ? "R8" : "R4") : "R5";
    end
    if (a1) begin
      m_pend = 0;
      tag = q ? "R6" : "R10";
      if (q) begin
        clr[w] = 1'b1;
        m_isr[w] = 1'b1;
        m_num = w;
      end
    end
    if (a2) begin
      m_vec = m_num; m_load = 1; tag = "R7";
    end
    if (eoi) begin
      t = top_bit(m_isr);
      if (t >= 0) m_isr[t] = 1'b0;
      tag = "R9";
    end
    m_req = (m_req & ~clr) | setv;
    m_prev = lv;
    @(posedge clk);
    #1;
    check(tag, irq_pending, m_pend, "irq_pending");
    check(tag, vec_load, m_load, "vec_load");
    check(tag, vec_num, m_vec, "vec_num");
    ask_stb = 0; ack1_stb = 0; ack2_stb = 0; eoi_stb = 0;
  endtask

  // Full take: poll, acknowledge twice.
  task automatic take(input logic [LINES-1:0] lv);
    cyc(lv, 1, 1, 0, 0, 0);
    cyc(lv, 1, 0, 1, 0, 0);
    cyc(lv, 1, 0, 0, 1, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [LINES-1:0] lv;
    void'($urandom(32'd20231));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check("R1", irq_pending, 0, "irq_pending in reset");
    check("R1", vec_load, 0, "vec_load in reset");
    check("R1", vec_num, 0, "vec_num in reset");
    @(negedge clk) rst_n = 1'b1;
    cyc('0, 1, 0, 0, 0, 0);
    cyc('0, 1, 1, 0, 0, 0);   // R1: empty registers -> no pending

    // R2/R4/R6/R7: line 5 taken
    lv = 8'h20;
    cyc(lv, 1, 0, 0, 0, 0);
    take(lv);
    cyc(lv, 1, 0, 0, 0, 0);   // R7: pulse ends
    cyc(lv, 1, 1, 0, 0, 0);   // R2: held level not relatched
    // R8: line 6 blocked by 5 in service
    lv = 8'h60; cyc(lv, 1, 0, 0, 0, 0);
    cyc(lv, 1, 1, 0, 0, 0);
    // R3/R8: line 2 nests
    lv = 8'h64; cyc(lv, 1, 0, 0, 0, 0);
    take(lv);
    cyc(lv, 1, 0, 0, 0, 1);   // R9: retire 2
    cyc(lv, 1, 1, 0, 0, 0);   // 6 still blocked by 5
    cyc(lv, 1, 0, 0, 0, 1);   // R9: retire 5
    take(lv);                 // 6 taken
    cyc(lv, 1, 0, 0, 0, 1);
    // R3: lines 1 and 3 together
    lv = 8'h0A; cyc(lv, 1, 0, 0, 0, 0);
    take(lv);
    // R5: disabled poll and acknowledge
    cyc(lv, 0, 1, 0, 0, 0);
    cyc(lv, 0, 0, 1, 0, 0);
    cyc(lv, 0, 0, 0, 1, 0);
    cyc(lv, 1, 0, 0, 0, 1);
    take(lv);                 // 3 taken
    // R10: acknowledge with nothing qualifying
    cyc(lv, 1, 0, 1, 0, 0);
    cyc(lv, 1, 0, 0, 1, 0);
    cyc(lv, 1, 0, 0, 0, 1);
    cyc('0, 1, 1, 0, 0, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int s;
      for (int b = 0; b < LINES; b++) if ($urandom % 8 == 0) lv[b] = ~lv[b];
      s = $urandom % 8;
      cyc(lv, ($urandom % 6) != 0, s == 0, s == 1, s == 2, s == 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule